// File: doc/BRIEF.md
# DDR Write Burst Strobe Sequencer

This block is the controller-side transmit path for write bursts to a double-data-rate memory. It runs on a clock at twice the memory clock rate. An internal phase bit marks which edges of this fast clock are memory-clock rising edges. Each fast-clock cycle is one half-clock "slot" on the memory interface. Every output is registered and changes once per slot. A write request carries a burst-length code. The block pulls one data word and its byte mask per slot from an upstream stream. It sends each word out together with a strobe level: the strobe is high for even elements and low for odd elements, so the elements sit on alternating strobe edges, one pair per memory clock.

The command-to-first-rising-strobe delay is fixed at the nominal one memory clock. A low preamble comes before each fresh burst and a low postamble follows the last element. The output enables open one slot ahead of the preamble and close once the postamble slot is over. A later write may be issued on any memory-clock rising edge. Its data takes over exactly two slots after its acceptance. The earlier burst therefore keeps as many element pairs as there are clocks between the two commands. This one rule covers both seamless concatenation and truncation. When the data stream runs dry during a burst, the element is still sent, but fully masked, and an error pulse is raised.

Top module: `ddrw_seq`

## Requirements
- R1: `wr_ready` is high on every other fast-clock cycle, and is high in the first cycle after reset. A write is accepted only at an edge where `wr_valid` and `wr_ready` are both high. `wr_valid` at any other edge is ignored.
- R2: For a write accepted at edge E (slot E is the cycle that follows edge E) onto an idle bus, `dqs_oe` and `dq_oe` are high from slot E onwards. `dqs_out` is low in slots E and E+1, and the first element goes out in slot E+2 with `dqs_out` high.
- R3: Burst-length code 0, 1, 2 and 3 on `wr_bl` gives 2, 4, 8 and 8 elements. Elements go out one per slot. `dqs_out` is high for element 0, 2, 4, … and low for element 1, 3, 5, ….
- R4: In the slot after the last element, if no newer burst takes over, both enables stay high with `dqs_out` low (postamble). In the slot after that, the enables drop unless a new write has reopened them.
- R5: When both enables are low, `dqs_out`, `dq_out`, `dm_out` and `underflow` are all 0. `in_ready` stays low, so stream data offered while idle is never taken.
- R6: A write accepted at edge E while an earlier burst is still running delivers its first element in slot E+2, right after the earlier burst's last element, with no idle slot and no preamble in between.
- R7: A write accepted x memory clocks after the previous one keeps exactly 2·x elements of the previous burst. The remaining elements of that burst are never requested and never sent.
- R8: Each element goes out on `dq_out` with its own `in_mask` value on `dm_out`, in the same slot. Masked elements are still sent.
- R9: If `in_valid` is low at an edge where `in_ready` is high, the slot that follows carries `dq_out` = 0, `dm_out` all ones and `underflow` = 1.
- R10: `in_ready` is high exactly in the cycle before each element's slot. The element is taken from `in_data`/`in_mask` at the edge that closes that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Fast clock at twice the memory clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_bl | input | 2 | Burst-length code (0:2, 1:4, 2/3:8 elements) |
| wr_ready | output | 1 | High on memory-clock rising edges; accept point |
| in_valid | input | 1 | Stream word available |
| in_data | input | DATA_W (16) | Stream data word |
| in_mask | input | DATA_W/8 (2) | Byte mask for the stream word |
| in_ready | output | 1 | Word is taken at the coming edge |
| dqs_out | output | 1 | Strobe level |
| dqs_oe | output | 1 | Strobe output enable |
| dq_out | output | DATA_W (16) | Data element |
| dm_out | output | DATA_W/8 (2) | Element mask |
| dq_oe | output | 1 | Data and mask output enable |
| underflow | output | 1 | Element sent masked because the stream was empty |

## Verification
The bench drives the worst cases for the splice logic: back-to-back bursts that must join without a hole, and short bursts that cut off an eight-element burst after one or three pairs. A design that counted the splice point wrongly would either leave a dead slot or send stale elements of the old burst. A write issued one clock after a postamble checks that the enable does not glitch low between the two bursts. A command on the off phase checks that a half-clock misalignment cannot slip in, since such a command would flip the strobe polarity for every element. Two missing stream words in the middle of a burst check that the design sends a fully masked element and does not shift the rest of the burst by one.

// File: rtl/ddrw_pkg.sv
package ddrw_pkg;
    // longest burst the block supports, in data elements
    localparam int MAX_ELEMS = 8;
    localparam int BLC_W     = 2;

    // burst-length code to element count; codes above 2 saturate
    function automatic int unsigned bl_elems(input logic [BLC_W-1:0] code);
        int unsigned n;
        if (code >= 2'd2) n = MAX_ELEMS;
        else              n = 2 << code;
        return n;
    endfunction
endpackage

// File: rtl/ddrw_cmd_pipe.sv
module ddrw_cmd_pipe #(
    parameter int CNT_W = 4
) (
    input  logic                      clk2x,
    input  logic                      rst_n,
    input  logic                      wr_valid,
    input  logic [ddrw_pkg::BLC_W-1:0] wr_bl,
    output logic                      wr_ready,
    output logic                      accept,
    output logic                      pre,
    output logic                      load,
    output logic [CNT_W-1:0]          load_len
);
    typedef struct packed {
        logic             phase;
        logic             arm1;
        logic             arm2;
        logic [CNT_W-1:0] len1;
        logic [CNT_W-1:0] len2;
    } cmd_st_t;

    cmd_st_t st_d, st_q;
    logic    acc_c;

    always_comb begin
        st_d       = st_q;
        st_d.phase = ~st_q.phase;
        acc_c      = wr_valid & ~st_q.phase;
        st_d.arm1  = acc_c;
        if (acc_c) st_d.len1 = CNT_W'(ddrw_pkg::bl_elems(wr_bl));
        st_d.arm2  = st_q.arm1;
        st_d.len2  = st_q.len1;
    end

    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_ready = ~st_q.phase;
    assign accept   = acc_c;
    assign pre      = st_q.arm1;
    assign load     = st_q.arm2;
    assign load_len = st_q.len2;

    // R1
    ready_alt_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        wr_ready |=> !wr_ready);
    // R1
    ready_back_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        !wr_ready |=> wr_ready);
    // R2
    arm_after_accept_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        accept |=> pre ##1 load);
endmodule

// File: rtl/ddrw_elem_ctr.sv
module ddrw_elem_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk2x,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    output logic             slot_data,
    output logic             slot_hi,
    output logic             slot_post
);
    typedef struct packed {
        logic [CNT_W-1:0] left;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)                   st_d.left = load_len;
        else if (st_q.left != '0)   st_d.left = st_q.left - 1'b1;
        else                        st_d.left = '0;
        slot_data = (st_d.left != '0);
        slot_hi   = slot_data & ~st_d.left[0];
        slot_post = (st_q.left == CNT_W'(1)) & ~load;
    end

    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    post_no_data_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        slot_post |-> !slot_data);
endmodule

// File: rtl/ddrw_out_stage.sv
module ddrw_out_stage #(
    parameter int DATA_W = 16,
    parameter int MASK_W = DATA_W / 8
) (
    input  logic              clk2x,
    input  logic              rst_n,
    input  logic              slot_data,
    input  logic              slot_hi,
    input  logic              slot_post,
    input  logic              lead,
    input  logic              pre,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [MASK_W-1:0] in_mask,
    output logic              dqs_out,
    output logic              dqs_oe,
    output logic [DATA_W-1:0] dq_out,
    output logic [MASK_W-1:0] dm_out,
    output logic              dq_oe,
    output logic              underflow
);
    typedef struct packed {
        logic              dqs;
        logic              dqs_en;
        logic [DATA_W-1:0] dq;
        logic [MASK_W-1:0] dm;
        logic              dq_en;
        logic              uf;
    } out_st_t;

    out_st_t st_d, st_q;
    logic    en_c;

    always_comb begin
        st_d        = '0;
        en_c        = lead | pre | slot_data | slot_post;
        st_d.dqs_en = en_c;
        st_d.dq_en  = en_c;
        st_d.dqs    = slot_hi;
        if (slot_data) begin
            if (in_valid) begin
                st_d.dq = in_data;
                st_d.dm = in_mask;
            end else begin
                st_d.dm = '1;
                st_d.uf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dqs_out   = st_q.dqs;
    assign dqs_oe    = st_q.dqs_en;
    assign dq_out    = st_q.dq;
    assign dm_out    = st_q.dm;
    assign dq_oe     = st_q.dq_en;
    assign underflow = st_q.uf;

    // R9
    underflow_mask_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        underflow |-> (dm_out == '1) && (dq_out == '0));
endmodule

// File: rtl/ddrw_seq.sv
module ddrw_seq #(
    parameter int DATA_W = 16
) (
    input  logic                  clk2x,
    input  logic                  rst_n,
    input  logic                  wr_valid,
    input  logic [1:0]            wr_bl,
    output logic                  wr_ready,
    input  logic                  in_valid,
    input  logic [DATA_W-1:0]     in_data,
    input  logic [DATA_W/8-1:0]   in_mask,
    output logic                  in_ready,
    output logic                  dqs_out,
    output logic                  dqs_oe,
    output logic [DATA_W-1:0]     dq_out,
    output logic [DATA_W/8-1:0]   dm_out,
    output logic                  dq_oe,
    output logic                  underflow
);
    localparam int MASK_W = DATA_W / 8;
    localparam int CNT_W  = $clog2(ddrw_pkg::MAX_ELEMS + 1);

    logic             accept, pre, load;
    logic [CNT_W-1:0] load_len;
    logic             slot_data, slot_hi, slot_post;

    ddrw_cmd_pipe #(.CNT_W(CNT_W)) u_cmd (
        .clk2x    (clk2x),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_bl    (wr_bl),
        .wr_ready (wr_ready),
        .accept   (accept),
        .pre      (pre),
        .load     (load),
        .load_len (load_len)
    );

    ddrw_elem_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk2x     (clk2x),
        .rst_n     (rst_n),
        .load      (load),
        .load_len  (load_len),
        .slot_data (slot_data),
        .slot_hi   (slot_hi),
        .slot_post (slot_post)
    );

    ddrw_out_stage #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_out (
        .clk2x     (clk2x),
        .rst_n     (rst_n),
        .slot_data (slot_data),
        .slot_hi   (slot_hi),
        .slot_post (slot_post),
        .lead      (accept),
        .pre       (pre),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_mask   (in_mask),
        .dqs_out   (dqs_out),
        .dqs_oe    (dqs_oe),
        .dq_out    (dq_out),
        .dm_out    (dm_out),
        .dq_oe     (dq_oe),
        .underflow (underflow)
    );

    assign in_ready = slot_data;

    // R2
    strobe_enabled_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        dqs_out |-> dqs_oe);
    // R2
    preamble_low_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        $rose(dqs_oe) |-> !dqs_out ##1 (!dqs_out && dqs_oe));
    // R3
    strobe_fall_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        dqs_out |=> dqs_oe && !dqs_out);
    // R5
    idle_quiet_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        !dq_oe |-> (dq_out == '0) && (dm_out == '0) && !dqs_out && !underflow);
    // R10
    taken_enabled_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        in_ready |=> dq_oe);
endmodule

// File: tb/ddrw_seq_tb.sv
`timescale 1ns/1ps
module ddrw_seq_tb;
    localparam int NS = 256;
    localparam int RUN = 160;

    logic        clk2x = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [1:0]  wr_bl = 2'd0;
    logic        wr_ready;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic [1:0]  in_mask = '0;
    logic        in_ready;
    logic        dqs_out, dqs_oe, dq_oe, underflow;
    logic [15:0] dq_out;
    logic [1:0]  dm_out;

    always #2.5 clk2x = ~clk2x;

    ddrw_seq u_dut (
        .clk2x(clk2x), .rst_n(rst_n), .wr_valid(wr_valid), .wr_bl(wr_bl),
        .wr_ready(wr_ready), .in_valid(in_valid), .in_data(in_data),
        .in_mask(in_mask), .in_ready(in_ready), .dqs_out(dqs_out),
        .dqs_oe(dqs_oe), .dq_out(dq_out), .dm_out(dm_out), .dq_oe(dq_oe),
        .underflow(underflow)
    );

    // scoreboard table: expected pin values per slot
    bit          e_oe  [NS];
    bit          e_dqs [NS];
    bit          e_dat [NS];
    bit          e_uf  [NS];
    logic [15:0] e_dq  [NS];
    logic [1:0]  e_dm  [NS];
    string       e_tag [NS];

    int n_cmp = 0;
    int n_bad = 0;
    int cur   = -1;
    bit done  = 1'b0;

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s slot %0d: actual %0h expected %0h", req, what, cur, act, exp);
        end
    endtask

    // driver side: a write accepted at edge e takes over from slot e+2
    task automatic model_write(int e, int n, string tag);
        for (int t = e + 2; t < NS; t++) begin
            e_oe[t] = 0; e_dqs[t] = 0; e_dat[t] = 0; e_uf[t] = 0;
            e_dq[t] = '0; e_dm[t] = '0; e_tag[t] = "";
        end
        e_oe[e] = 1;
        e_oe[e+1] = 1;
        for (int i = 0; i < n; i++) begin
            e_oe[e+2+i]  = 1;
            e_dat[e+2+i] = 1;
            e_dqs[e+2+i] = (i % 2 == 0);
            e_tag[e+2+i] = tag;
        end
        e_oe[e+2+n] = 1;
    endtask

    task automatic drive_edge(int s);
        int    code;
        string tag;
        bit    v;
        code = -1;
        tag  = "";
        case (s)
            0:   begin code = 1; tag = "R2"; end
            10:  begin code = 0; tag = "R3"; end
            20:  begin code = 2; tag = "R9"; end
            40:  begin code = 1; tag = "R6"; end
            44:  begin code = 1; tag = "R6"; end
            60:  begin code = 2; tag = "R7"; end
            62:  begin code = 0; tag = "R7"; end
            80:  begin code = 1; tag = "R4"; end
            86:  begin code = 1; tag = "R4"; end
            100: begin code = 3; tag = "R3"; end
            120: begin code = 2; tag = "R7"; end
            126: begin code = 1; tag = "R7"; end
            131: begin code = 1; tag = "R1"; end
            default: ;
        endcase
        chk("R1", "wr_ready", int'(wr_ready), (s % 2 == 0) ? 1 : 0);
        chk(e_dat[s] ? "R10" : "R5", "in_ready", int'(in_ready), int'(e_dat[s]));
        wr_valid = (code >= 0);
        wr_bl    = (code >= 0) ? 2'(code) : 2'd0;
        if (code >= 0 && (s % 2 == 0))
            model_write(s, (code == 0) ? 2 : (code == 1) ? 4 : 8, tag);
        v        = !(s == 25 || s == 26);
        in_valid = v;
        in_data  = {s[7:0] ^ 8'h5A, s[7:0]};
        in_mask  = s[1:0];
        if (e_dat[s]) begin
            e_dq[s] = v ? in_data : 16'h0;
            e_dm[s] = v ? in_mask : 2'b11;
            e_uf[s] = !v;
        end
    endtask

    // monitor side: compare pins with the table entry of the slot
    task automatic check_slot(int s);
        string oet;
        cur = s;
        oet = !e_oe[s] ? "R5" : (e_dat[s] ? "R3" : "R2/R4");
        chk(oet, "dqs_oe", int'(dqs_oe), int'(e_oe[s]));
        chk(oet, "dq_oe", int'(dq_oe), int'(e_oe[s]));
        chk("R3", "dqs_out", int'(dqs_out), int'(e_dqs[s]));
        chk((e_tag[s] != "") ? e_tag[s] : "R8", "dq_out", int'(dq_out), int'(e_dq[s]));
        chk("R8", "dm_out", int'(dm_out), int'(e_dm[s]));
        chk("R9", "underflow", int'(underflow), int'(e_uf[s]));
    endtask

    initial begin
        repeat (3) @(negedge clk2x);
        // R5: quiet pins in reset
        chk("R5", "reset dqs_oe", int'(dqs_oe), 0);
        chk("R5", "reset dq_oe", int'(dq_oe), 0);
        chk("R5", "reset dq_out", int'(dq_out), 0);
        chk("R5", "reset in_ready", int'(in_ready), 0);
        rst_n = 1'b1;
        for (int s = 0; s < RUN; s++) begin
            cur = s - 1;
            drive_edge(s);
            @(negedge clk2x);
            check_slot(s);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule